// File: doc/BRIEF.md
# Edge-Triggered Set/Clear Bit Register

This block is a small bank of independent storage bits, three by default. Each bit has four control inputs of its own: a data line, a bit clock, a set line and a clear line. All of them are sampled in one fast system clock domain. A bit loads its data line when its bit clock rises. It is forced high when its set line rises and forced low when its clear line rises.

Set and clear act only on their rising transitions, not on their levels. Software or surrounding logic can therefore pulse a bit to a known value and leave the set or clear line high, and the next bit-clock rise still loads data as usual. Each bit drives a true output and a complemented output.

Every per-bit input passes through a two-stage synchronizer. Rising transitions are found by comparing the synchronized sample with the one held from the previous system cycle. The stored bit updates on the following system edge. An input change that is set up before system edge E1 therefore shows on the outputs after system edge E3.

Top module: `edge_sr_reg`

## Requirements
- R1: While `sys_rst` is high at a system clock edge, every bit of `q` is cleared to 0 on that edge, every bit of `q_n` reads 1, and all synchronizer and edge-history state is cleared.
- R2: A rising transition on `bit_clk[i]` loads `din[i]` into `q[i]`, whether `din[i]` is 0 or 1.
- R3: A rising transition on `set_req[i]` drives `q[i]` to 1, whatever the data and bit-clock values are.
- R4: A rising transition on `clr_req[i]` drives `q[i]` to 0, whatever the data and bit-clock values are.
- R5: A `set_req[i]` or `clr_req[i]` line that stays high after its rising transition has no further effect, and the next bit-clock rise loads data normally.
- R6: `q_n` is always the bitwise complement of `q`.
- R7: When a set or clear rise lands in the same synchronized sample as a bit-clock rise, the set or clear wins and the data load is discarded.
- R8: When set and clear rises land in the same synchronized sample, clear wins and the bit goes to 0.
- R9: An input change applied before system edge n shows on `q` and `q_n` just after system edge n+2, and not earlier. A bit with no rising control transition keeps its value.
- R10: Activity on the inputs of one bit never changes the value held by any other bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System sampling clock |
| sys_rst | input | 1 | Synchronous active-high reset |
| din | input | NUM_BITS | Per-bit data lines |
| bit_clk | input | NUM_BITS | Per-bit load strobes, active on rising transition |
| set_req | input | NUM_BITS | Per-bit set lines, active on rising transition |
| clr_req | input | NUM_BITS | Per-bit clear lines, active on rising transition |
| q | output | NUM_BITS | Stored bit values |
| q_n | output | NUM_BITS | Complement of the stored bit values |

## Verification
The hardest cases to reach from the ports are the priority cases. These are a set or clear rise that meets a bit-clock rise, and a set rise that meets a clear rise, all inside one synchronized sample. The bench reaches them by changing the competing lines in the same system cycle, so that they cross the synchronizer together. It also leaves set and clear lines high across later bit-clock rises to show that a held level is ignored. A reference model in the bench predicts every bit on every cycle, three system edges after each stimulus.

// File: rtl/esr_pkg.sv
package esr_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_SET  = 2'd2,
        ACT_CLR  = 2'd3
    } act_e;

    typedef struct packed {
        logic clr_rise;
        logic set_rise;
        logic clk_rise;
        logic dat;
    } cell_in_t;

    // clear beats set, both beat a data load
    function automatic act_e pick_act(cell_in_t c);
        if (c.clr_rise)      return ACT_CLR;
        else if (c.set_rise) return ACT_SET;
        else if (c.clk_rise) return ACT_LOAD;
        else                 return ACT_HOLD;
    endfunction

    function automatic logic next_val(act_e a, logic cur, logic dat);
        case (a)
            ACT_CLR:  return 1'b0;
            ACT_SET:  return 1'b1;
            ACT_LOAD: return dat;
            default:  return cur;
        endcase
    endfunction

endpackage

// File: rtl/esr_sync.sv
module esr_sync #(
    parameter int WIDTH  = 12,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= '0;
        else     pipe[0] <= async_in;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= '0;
                else     pipe[s] <= pipe[s-1];
            end
        end
    endgenerate

    assign sync_out = pipe[STAGES-1];
endmodule

// File: rtl/esr_rise.sv
module esr_rise #(
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= cur;
    end

    assign rise = cur & ~prev;
endmodule

// File: rtl/esr_cell.sv
module esr_cell
    import esr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cell_in_t cin,
    output logic     q
);
    act_e act;

    always_comb act = pick_act(cin);

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= next_val(act, q, cin.dat);
    end
endmodule

// File: rtl/edge_sr_reg.sv
module edge_sr_reg
    import esr_pkg::*;
#(
    parameter int NUM_BITS    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                sys_clk,
    input  logic                sys_rst,
    input  logic [NUM_BITS-1:0] din,
    input  logic [NUM_BITS-1:0] bit_clk,
    input  logic [NUM_BITS-1:0] set_req,
    input  logic [NUM_BITS-1:0] clr_req,
    output logic [NUM_BITS-1:0] q,
    output logic [NUM_BITS-1:0] q_n
);
    localparam int CTRL_W = 3 * NUM_BITS;
    localparam int ALL_W  = CTRL_W + NUM_BITS;

    logic [ALL_W-1:0]    raw_all;
    logic [ALL_W-1:0]    smp_all;
    logic [CTRL_W-1:0]   ctrl_rise;
    logic [NUM_BITS-1:0] d_smp;
    logic [NUM_BITS-1:0] clk_rise;
    logic [NUM_BITS-1:0] set_rise;
    logic [NUM_BITS-1:0] clr_rise;

    assign raw_all = {clr_req, set_req, bit_clk, din};

    esr_sync #(.WIDTH(ALL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (sys_clk),
        .rst      (sys_rst),
        .async_in (raw_all),
        .sync_out (smp_all)
    );

    assign d_smp = smp_all[NUM_BITS-1:0];

    esr_rise #(.WIDTH(CTRL_W)) u_rise (
        .clk  (sys_clk),
        .rst  (sys_rst),
        .cur  (smp_all[ALL_W-1:NUM_BITS]),
        .rise (ctrl_rise)
    );

    assign clk_rise = ctrl_rise[NUM_BITS-1:0];
    assign set_rise = ctrl_rise[2*NUM_BITS-1:NUM_BITS];
    assign clr_rise = ctrl_rise[CTRL_W-1:2*NUM_BITS];

    generate
        for (genvar i = 0; i < NUM_BITS; i++) begin : g_bit
            cell_in_t cin;
            assign cin = '{clr_rise: clr_rise[i], set_rise: set_rise[i],
                           clk_rise: clk_rise[i], dat: d_smp[i]};
            esr_cell u_cell (
                .clk (sys_clk),
                .rst (sys_rst),
                .cin (cin),
                .q   (q[i])
            );
        end
    endgenerate

    assign q_n = ~q;
endmodule

// File: rtl/esr_chk.sv
module esr_chk #(
    parameter int NUM_BITS = 3
) (
    input logic                sys_clk,
    input logic                sys_rst,
    input logic [NUM_BITS-1:0] q,
    input logic [NUM_BITS-1:0] q_n,
    input logic [NUM_BITS-1:0] clk_rise,
    input logic [NUM_BITS-1:0] set_rise,
    input logic [NUM_BITS-1:0] clr_rise,
    input logic [NUM_BITS-1:0] d_smp
);
    // R6
    compl_out_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
        q_n == ~q);

    generate
        for (genvar i = 0; i < NUM_BITS; i++) begin : g_b
            // R4 R8
            clr_wins_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
                clr_rise[i] |=> !q[i]);
            // R3 R7
            set_wins_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
                (set_rise[i] && !clr_rise[i]) |=> q[i]);
            // R2
            load_data_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
                (clk_rise[i] && !set_rise[i] && !clr_rise[i]) |=> (q[i] == $past(d_smp[i])));
            // R9 R10
            hold_idle_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
                (!clk_rise[i] && !set_rise[i] && !clr_rise[i]) |=> $stable(q[i]));
        end
    endgenerate
endmodule

bind edge_sr_reg esr_chk #(.NUM_BITS(NUM_BITS)) u_esr_chk (
    .sys_clk  (sys_clk),
    .sys_rst  (sys_rst),
    .q        (q),
    .q_n      (q_n),
    .clk_rise (clk_rise),
    .set_rise (set_rise),
    .clr_rise (clr_rise),
    .d_smp    (d_smp)
);

// File: tb/tb_edge_sr_reg.sv
module tb_edge_sr_reg;
    localparam int N = 3;

    logic         sys_clk = 1'b0;
    logic         sys_rst = 1'b1;
    logic [N-1:0] din = '0, bit_clk = '0, set_req = '0, clr_req = '0;
    logic [N-1:0] q, q_n;

    edge_sr_reg #(.NUM_BITS(N)) dut (
        .sys_clk (sys_clk),
        .sys_rst (sys_rst),
        .din     (din),
        .bit_clk (bit_clk),
        .set_req (set_req),
        .clr_req (clr_req),
        .q       (q),
        .q_n     (q_n)
    );

    always #10 sys_clk = ~sys_clk;

    typedef struct {
        int           due;
        logic [N-1:0] exp;
        string        tag;
    } item_t;

    item_t        sb[$];
    int           cyc = 0;
    int           total = 0;
    int           bad = 0;
    logic [N-1:0] m_q = '0;
    logic [N-1:0] p_clk = '0, p_set = '0, p_clr = '0;

    always @(posedge sys_clk) cyc <= cyc + 1;

    task automatic chk(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // driver: apply one stimulus vector and queue the predicted state
    task automatic step(input logic [N-1:0] d, input logic [N-1:0] c,
                        input logic [N-1:0] s, input logic [N-1:0] r, input string tag);
        item_t it;
        @(negedge sys_clk);
        for (int i = 0; i < N; i++) begin
            if (r[i] && !p_clr[i])      m_q[i] = 1'b0;
            else if (s[i] && !p_set[i]) m_q[i] = 1'b1;
            else if (c[i] && !p_clk[i]) m_q[i] = d[i];
        end
        p_clk = c; p_set = s; p_clr = r;
        din = d; bit_clk = c; set_req = s; clr_req = r;
        it.due = cyc + 3;
        it.exp = m_q;
        it.tag = tag;
        sb.push_back(it);
    endtask

    // monitor: compare each due item away from the active edge
    initial begin
        forever begin
            @(negedge sys_clk);
            #2;
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                item_t it;
                it = sb.pop_front();
                chk(q, it.exp, it.tag);
                chk(q_n, ~it.exp, "R6 complement");
            end
        end
    end

    initial begin
        repeat (1000) @(posedge sys_clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge sys_clk);
        #2;
        chk(q, '0, "R1 reset q");
        chk(q_n, '1, "R1 reset q_n");
        @(negedge sys_clk);
        sys_rst = 1'b0;

        // R2 load ones and zeros, R9 latency via per-cycle items
        step(3'b101, 3'b000, 3'b000, 3'b000, "R2 idle");
        step(3'b101, 3'b111, 3'b000, 3'b000, "R2 load 101");
        step(3'b010, 3'b111, 3'b000, 3'b000, "R9 no rise hold");
        step(3'b010, 3'b000, 3'b000, 3'b000, "R9 clk fall hold");
        step(3'b010, 3'b111, 3'b000, 3'b000, "R2 load 010");
        step(3'b010, 3'b000, 3'b000, 3'b000, "R2 settle");
        // R3 set with data low and clock toggling on the same bit
        step(3'b000, 3'b000, 3'b001, 3'b000, "R3 set bit0");
        step(3'b000, 3'b001, 3'b001, 3'b000, "R5 set held, load 0");
        step(3'b000, 3'b000, 3'b001, 3'b000, "R5 settle");
        // R4 clear then held while loading a one
        step(3'b111, 3'b000, 3'b001, 3'b010, "R4 clear bit1");
        step(3'b010, 3'b010, 3'b001, 3'b010, "R5 clr held, load 1");
        step(3'b000, 3'b000, 3'b000, 3'b000, "R5 release");
        // R7 set rise with clock rise, data low; clear rise with clock rise, data high
        step(3'b100, 3'b101, 3'b001, 3'b100, "R7 set/clr beat load");
        step(3'b000, 3'b000, 3'b000, 3'b000, "R7 settle");
        // R8 set and clear together
        step(3'b000, 3'b000, 3'b111, 3'b111, "R8 clear beats set");
        step(3'b000, 3'b000, 3'b000, 3'b000, "R8 settle");
        // R10 only bit2 active; others must keep their values
        step(3'b000, 3'b000, 3'b011, 3'b000, "R10 set bits 1:0");
        step(3'b100, 3'b100, 3'b011, 3'b000, "R10 bit2 load");
        step(3'b000, 3'b000, 3'b011, 3'b100, "R10 bit2 clear");
        step(3'b100, 3'b100, 3'b011, 3'b100, "R10 bit2 load w/ clr held");
        for (int k = 0; k < 4; k++) step(3'b000, 3'b000, 3'b000, 3'b000, "R9 drain");

        while (sb.size() > 0) @(negedge sys_clk);
        #5;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule